// File: doc/BRIEF.md
# Branch and Delay-Slot Sequencer

This block owns the program counter of a small integer/vector coprocessor. It receives one decoded instruction per cycle. For that instruction it gets a class code, the index of the second source register, the two 16-bit register values already read from the register file, and a signed word offset. From these it decides whether the instruction redirects control flow and where it goes. Every taken transfer has one delay slot: the instruction after the branch always executes, and the target instruction runs after it.

The unusual part is a branch placed in the delay slot of an earlier taken branch. A plain slot branch is chained. Control first moves to the earlier target. Two instructions run from there, and then control moves to the slot branch's target. A linking slot branch that names a nonzero link register is different. It still writes its link value, but its transfer is dropped. The two linking classes send a return index (PC + 8) / 8 to the register file as a single-cycle write pulse.

Top module: `vbs_seq`

## Requirements
- R1: After synchronous reset, `pc` is 0, `link_we` is low, and no transfer is pending.
- R2: When no redirect falls due, each cycle with `instr_valid` high advances `pc` by 8. Cycles with `instr_valid` low leave `pc` and all pending state unchanged.
- R3: Class 1 (equal) and class 2 (not equal) compare `is_val` and `it_val` as full 16-bit unsigned values.
- R4: Classes 3, 4, 5 and 6 take the branch when `is_val`, read as a signed 16-bit number, is >= 0, > 0, <= 0 and < 0 respectively. Class 0 is not a transfer.
- R5: Conditional classes and class 7 (always) target `pc + 8 + br_off*8`, with `br_off` sign-extended and the sum taken modulo 2^16. After a taken transfer, the next instruction runs at `pc + 8` and the one after it runs at the target.
- R6: Class 9 (register jump) and class 10 (register jump with link) target `is_val*8`, truncated to 16 bits.
- R7: Class 8 (relative with link) and class 10 raise `link_we` in their own cycle when `it_idx` is nonzero. The pulse carries `link_idx = it_idx` and `link_data = (pc + 8) / 8`, computed without losing the carry. When `it_idx` is 0 there is no write.
- R8: A taken non-linking transfer in a delay slot is chained. The first target and the instruction after it both execute, and then `pc` moves to the slot transfer's target.
- R9: A linking transfer in a delay slot with a nonzero `it_idx` is dropped, so execution continues sequentially from the first target. With `it_idx` of 0, the same transfer is chained as in R8.
- R10: Slot-transfer state is cleared once the first transfer completes. A later slot transfer after a dropped one chains normally, and a completed chain causes no further redirect.
- R11: A taken transfer that runs at the first target of a chain replaces the pending chained target. Its own delay slot then follows.
- R12: `pc_next` shows the value `pc` will take at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction executes this cycle |
| op | input | 4 | Instruction class code |
| it_idx | input | 4 | Index of the second source / link register |
| is_val | input | 16 | Value of the first source register |
| it_val | input | 16 | Value of the second source register |
| br_off | input | 11 | Signed offset in 8-byte units |
| pc | output | 16 | Byte address of the executing instruction |
| pc_next | output | 16 | Value of `pc` after this edge |
| link_we | output | 1 | Link register write pulse |
| link_idx | output | 4 | Link register index |
| link_data | output | 16 | Return index (PC + 8) / 8 |

## Verification
Two things can happen in the same cycle. The pending transfer can complete, and a new transfer, executing in that same slot, can be evaluated. Whether the new transfer is chained, dropped or replaces the pending one is decided by combinational logic within that single cycle. Linking transfers also add a register write-back to that cycle. The scenarios place plain, linking and zero-index linking transfers directly in delay slots and at the first chained target. Each one is judged by the exact PC sequence that follows and by the link pulse seen in the slot cycle.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  parameter int PC_W  = 16;
  parameter int REG_W = 16;
  parameter int IDX_W = 4;
  parameter int OFF_W = 11;
  localparam int CNT_W = 2;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_BEQ  = 4'd1,
    OP_BNE  = 4'd2,
    OP_BGEZ = 4'd3,
    OP_BGTZ = 4'd4,
    OP_BLEZ = 4'd5,
    OP_BLTZ = 4'd6,
    OP_B    = 4'd7,
    OP_BAL  = 4'd8,
    OP_JR   = 4'd9,
    OP_JALR = 4'd10
  } op_e;

  function automatic logic f_cond(op_e op, logic [REG_W-1:0] a, logic [REG_W-1:0] b);
    logic signed [REG_W-1:0] sa;
    sa = $signed(a);
    case (op)
      OP_BEQ:  return a == b;
      OP_BNE:  return a != b;
      OP_BGEZ: return sa >= 0;
      OP_BGTZ: return sa > 0;
      OP_BLEZ: return sa <= 0;
      OP_BLTZ: return sa < 0;
      OP_B, OP_BAL, OP_JR, OP_JALR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] f_rel_target(logic [PC_W-1:0] pc, logic [OFF_W-1:0] off);
    logic signed [PC_W-1:0] so;
    so = PC_W'($signed(off));
    return pc + PC_W'(8) + PC_W'(so <<< 3);
  endfunction

  function automatic logic [PC_W-1:0] f_reg_target(logic [REG_W-1:0] v);
    return PC_W'({v, 3'b000});
  endfunction

  function automatic logic [REG_W-1:0] f_link_value(logic [PC_W-1:0] pc);
    logic [PC_W:0] s;
    s = {1'b0, pc} + (PC_W+1)'(8);
    return REG_W'(s >> 3);
  endfunction
endpackage

// File: rtl/vbs_branch_eval.sv
module vbs_branch_eval
  import vbs_pkg::*;
(
  input  logic [3:0]       op,
  input  logic [REG_W-1:0] is_val,
  input  logic [REG_W-1:0] it_val,
  input  logic [OFF_W-1:0] br_off,
  input  logic [PC_W-1:0]  pc,
  output logic             taken,
  output logic             is_link,
  output logic [PC_W-1:0]  target
);
  op_e opc;

  always_comb begin
    opc     = op_e'(op);
    taken   = f_cond(opc, is_val, it_val);
    is_link = (opc == OP_BAL) || (opc == OP_JALR);
    if (opc == OP_JR || opc == OP_JALR)
      target = f_reg_target(is_val);
    else
      target = f_rel_target(pc, br_off);
  end
endmodule

// File: rtl/vbs_pending.sv
module vbs_pending
  import vbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             taken,
  input  logic             is_link,
  input  logic [IDX_W-1:0] it_idx,
  input  logic [PC_W-1:0]  target,
  output logic             redirect,
  output logic [PC_W-1:0]  redir_pc
);
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [PC_W-1:0]  tgt, tgt_n;
  logic in_slot, slot_take, slot_drop, chain;

  always_comb begin
    in_slot   = (cnt == CNT_W'(1));
    slot_take = valid && taken && in_slot;
    slot_drop = slot_take && is_link && (it_idx != '0);
    chain     = slot_take && !slot_drop;
    redirect  = valid && in_slot;
    redir_pc  = tgt;
    cnt_n     = cnt;
    tgt_n     = tgt;
    if (valid) begin
      if (in_slot) begin
        if (chain) begin
          cnt_n = CNT_W'(2);
          tgt_n = target;
        end else begin
          cnt_n = '0;
        end
      end else if (taken) begin
        cnt_n = CNT_W'(1);
        tgt_n = target;
      end else if (cnt != '0) begin
        cnt_n = cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgt <= '0;
    end else begin
      cnt <= cnt_n;
      tgt <= tgt_n;
    end
  end

  p_arm_r5: assert property (@(posedge clk) disable iff (rst)
    (valid && taken && cnt == '0) |=> (cnt == CNT_W'(1)));
  p_chain_rearm_r8: assert property (@(posedge clk) disable iff (rst)
    chain |=> (cnt == CNT_W'(2)));
  p_drop_r9: assert property (@(posedge clk) disable iff (rst)
    slot_drop |=> (cnt == '0));
  p_cnt_legal_r11: assert property (@(posedge clk) disable iff (rst)
    cnt != CNT_W'(3));
endmodule

// File: rtl/vbs_seq.sv
module vbs_seq
  import vbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [3:0]       op,
  input  logic [IDX_W-1:0] it_idx,
  input  logic [REG_W-1:0] is_val,
  input  logic [REG_W-1:0] it_val,
  input  logic [OFF_W-1:0] br_off,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  pc_next,
  output logic             link_we,
  output logic [IDX_W-1:0] link_idx,
  output logic [REG_W-1:0] link_data
);
  logic            br_taken, br_link, redirect;
  logic [PC_W-1:0] br_target, redir_pc;

  vbs_branch_eval u_eval (
    .op(op), .is_val(is_val), .it_val(it_val), .br_off(br_off), .pc(pc),
    .taken(br_taken), .is_link(br_link), .target(br_target)
  );

  vbs_pending u_pend (
    .clk(clk), .rst(rst), .valid(instr_valid), .taken(br_taken),
    .is_link(br_link), .it_idx(it_idx), .target(br_target),
    .redirect(redirect), .redir_pc(redir_pc)
  );

  always_comb begin
    if (!instr_valid)  pc_next = pc;
    else if (redirect) pc_next = redir_pc;
    else               pc_next = pc + PC_W'(8);
    link_we   = instr_valid && br_link && (it_idx != '0);
    link_idx  = it_idx;
    link_data = f_link_value(pc);
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  p_seq_adv_r2: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !redirect) |=> (pc == $past(pc) + PC_W'(8)));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(pc));
  p_link_idx_r7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_idx != '0 && (op == 4'd8 || op == 4'd10)));
endmodule

// File: tb/vbs_seq_test.sv
module vbs_seq_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        instr_valid = 0;
  logic [3:0]  op = 0;
  logic [3:0]  it_idx = 0;
  logic [15:0] is_val = 0, it_val = 0;
  logic [10:0] br_off = 0;
  logic [15:0] pc, pc_next, link_data;
  logic        link_we;
  logic [3:0]  link_idx;

  int checks = 0, errors = 0, cycles = 0;
  logic        c_we;
  logic [3:0]  c_idx;
  logic [15:0] c_data, c_next;
  logic [15:0] cur;

  vbs_seq uut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act %0d cycles exp < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; instr_valid = 0; op = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  // Runs one instruction; checks the PC it executes at.
  task automatic step(input logic [15:0] exp_pc, input int o, input int it,
                      input int isv, input int itv, input int off, input string tag);
    @(negedge clk);
    chk(pc == exp_pc, tag, pc, exp_pc);
    instr_valid = 1; op = 4'(o); it_idx = 4'(it);
    is_val = 16'(isv); it_val = 16'(itv); br_off = 11'(off);
    #1;
    c_we = link_we; c_idx = link_idx; c_data = link_data; c_next = pc_next;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 0; op = 0;
  endtask

  // Conditional case at cur: off=3 gives target cur+32, fallthrough cur+16.
  task automatic cond_case(input int o, input int isv, input int itv,
                           input logic exp_t, input string tag);
    step(cur, o, 0, isv, itv, 3, tag);
    step(cur + 16'd8, 0, 0, 0, 0, 0, tag);
    cur = exp_t ? cur + 16'd32 : cur + 16'd16;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(pc == 0, "R1 pc", pc, 0);
    chk(link_we == 0, "R1 link_we", link_we, 0);
    chk(pc_next == 0, "R12 idle next", pc_next, 0);
    step(16'd0, 0, 0, 0, 0, 0, "R1 first");
    step(16'd8, 0, 0, 0, 0, 0, "R1 no pending");
  endtask

  task automatic t_seq();
    do_reset();
    step(16'd0, 0, 0, 0, 0, 0, "R2 a");
    step(16'd8, 0, 0, 0, 0, 0, "R2 b");
    chk(c_next == 16'd16, "R12 seq next", c_next, 16);
    idle(); idle(); idle();
    step(16'd16, 0, 0, 0, 0, 0, "R2 hold");
    step(16'd24, 0, 0, 0, 0, 0, "R2 c");
  endtask

  task automatic t_compare();
    do_reset(); cur = 0;
    cond_case(1, 'h8001, 'h8001, 1, "R3 beq eq");
    cond_case(1, 'hFFFF, 'h7FFF, 0, "R3 beq ne");
    cond_case(2, 'h8000, 'h0000, 1, "R3 bne ne");
    cond_case(2, 'h1234, 'h1234, 0, "R3 bne eq");
    step(cur, 0, 0, 0, 0, 0, "R3 end");
  endtask

  task automatic t_signed();
    do_reset(); cur = 0;
    cond_case(3, 'h8000, 0, 0, "R4 bgez neg");
    cond_case(3, 'h0000, 0, 1, "R4 bgez zero");
    cond_case(4, 'h0000, 0, 0, "R4 bgtz zero");
    cond_case(4, 'h7FFF, 0, 1, "R4 bgtz pos");
    cond_case(5, 'h0000, 0, 1, "R4 blez zero");
    cond_case(5, 'h0001, 0, 0, "R4 blez pos");
    cond_case(6, 'hFFFF, 0, 1, "R4 bltz neg");
    cond_case(6, 'h0000, 0, 0, "R4 bltz zero");
    cond_case(0, 'hFFFF, 0, 0, "R4 none");
    step(cur, 0, 0, 0, 0, 0, "R4 end");
  endtask

  task automatic t_relative();
    do_reset();
    step(16'd0, 7, 0, 0, 0, 10, "R5 b fwd");
    step(16'd8, 0, 0, 0, 0, 0, "R5 slot");
    chk(c_next == 16'd88, "R12 redirect next", c_next, 88);
    step(16'd88, 7, 0, 0, 0, -12, "R5 b back");
    step(16'd96, 0, 0, 0, 0, 0, "R5 slot2");
    step(16'd0, 0, 0, 0, 0, 0, "R5 back target");
  endtask

  task automatic t_register();
    do_reset();
    step(16'd0, 9, 0, 'h0010, 0, 0, "R6 jr");
    chk(c_we == 0, "R7 jr no link", c_we, 0);
    step(16'd8, 0, 0, 0, 0, 0, "R6 slot");
    step(16'd128, 10, 5, 'h2001, 0, 0, "R6 jalr");
    chk(c_we == 1, "R7 jalr we", c_we, 1);
    chk(c_idx == 5, "R7 jalr idx", c_idx, 5);
    chk(c_data == 16'd17, "R7 jalr data", c_data, 17);
    step(16'd136, 0, 0, 0, 0, 0, "R6 slot2");
    step(16'd8, 10, 0, 'h1FFF, 0, 0, "R6 trunc");
    chk(c_we == 0, "R7 idx0 no write", c_we, 0);
    step(16'd16, 0, 0, 0, 0, 0, "R6 slot3");
    step(16'hFFF8, 8, 3, 0, 0, 0, "R7 bal top");
    chk(c_we == 1, "R7 bal we", c_we, 1);
    chk(c_data == 16'h2000, "R7 bal carry", c_data, 'h2000);
    step(16'h0000, 0, 0, 0, 0, 0, "R5 wrap slot");
    step(16'h0000, 0, 0, 0, 0, 0, "R5 wrap target");
  endtask

  task automatic t_chain();
    do_reset();
    step(16'd0, 7, 0, 0, 0, 10, "R8 first");
    step(16'd8, 7, 0, 0, 0, 20, "R8 slot branch");
    step(16'd88, 0, 0, 0, 0, 0, "R8 first target");
    step(16'd96, 0, 0, 0, 0, 0, "R8 second");
    step(16'd176, 0, 0, 0, 0, 0, "R8 chained target");
    step(16'd184, 0, 0, 0, 0, 0, "R10 no more redirect");
  endtask

  task automatic t_drop();
    do_reset();
    step(16'd0, 7, 0, 0, 0, 10, "R9 first");
    step(16'd8, 8, 2, 0, 0, 20, "R9 link slot");
    chk(c_we == 1, "R9 link write kept", c_we, 1);
    chk(c_data == 16'd2, "R9 link data", c_data, 2);
    step(16'd88, 0, 0, 0, 0, 0, "R9 first target");
    step(16'd96, 0, 0, 0, 0, 0, "R9 seq");
    step(16'd104, 7, 0, 0, 0, 1, "R9 dropped");
    step(16'd112, 7, 0, 0, 0, 2, "R10 slot again");
    step(16'd120, 0, 0, 0, 0, 0, "R10 target");
    step(16'd128, 0, 0, 0, 0, 0, "R10 second");
    step(16'd136, 0, 0, 0, 0, 0, "R10 chained");
  endtask

  task automatic t_zero_link();
    do_reset();
    step(16'd0, 7, 0, 0, 0, 10, "R9 z first");
    step(16'd8, 10, 0, 'h0004, 0, 0, "R9 z slot");
    chk(c_we == 0, "R9 z no write", c_we, 0);
    step(16'd88, 0, 0, 0, 0, 0, "R9 z target");
    step(16'd96, 0, 0, 0, 0, 0, "R9 z second");
    step(16'd32, 0, 0, 0, 0, 0, "R9 z chained");
  endtask

  task automatic t_override();
    do_reset();
    step(16'd0, 7, 0, 0, 0, 10, "R11 first");
    step(16'd8, 7, 0, 0, 0, 20, "R11 slot");
    step(16'd88, 7, 0, 0, 0, 1, "R11 new");
    step(16'd96, 0, 0, 0, 0, 0, "R11 its slot");
    step(16'd104, 0, 0, 0, 0, 0, "R11 replaced");
    step(16'd112, 0, 0, 0, 0, 0, "R11 seq");
  endtask

  initial begin
    t_reset();
    t_seq();
    t_compare();
    t_signed();
    t_relative();
    t_register();
    t_chain();
    t_drop();
    t_zero_link();
    t_override();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule